// File: doc/BRIEF.md
# E1 Transmit Overhead Formatter

This block sits in the transmit path of an E1 framer, between the source of serial payload and the line coder. A transmit timing source supplies each bit with its position: the time slot, the bit within the slot, whether the current frame carries the frame alignment word, and the frame number within the multiframe. From that position the formatter decides where each output bit comes from. It can pass the serial input through, use a fixed alignment pattern, use a bit of one of two overhead registers, use an externally computed CRC bit, or use an automatically generated E-bit.

Three overrides sit on top of the overhead insertion. A pass-through control hands all of time slot 0 except the first bit back to the serial input. A signalling-ones control forces time slot 16 high in every frame. An unframed-ones control replaces the whole stream with ones and takes priority over everything else. The output is registered, so each bit appears one clock after its position is presented. CRC computation and line coding are not part of this block.

Top module: `txoh_fmt`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `txData` is 1.
- R2: For a bit of any time slot other than 0 (and other than 16 while `sigOnes` is set), with `unframedOnes` low, `txData` equals `serIn` one clock later.
- R3: In a frame with `fasFrame`=1 and `passThru`=0, bits 2 to 8 of time slot 0 (`bitIdx` 1 to 7) carry 0,0,1,1,0,1,1 in that order. With `passThru`=1 they carry `serIn`.
- R4: In a frame with `fasFrame`=0 and `passThru`=0, bit 2 of time slot 0 is forced to 1, and bits 3 to 8 (remote alarm and spare bits) take `nfasReg[7-bitIdx]`. With `passThru`=1 they carry `serIn`.
- R5: The first bit of time slot 0 (`bitIdx` 0) carries `serIn` when `intlSel`=0. When `intlSel`=1 and `passThru`=0, it carries bit 7 of `fasReg` in a frame with `fasFrame`=1 or bit 7 of `nfasReg` otherwise. When `intlSel`=1 and `passThru`=1, it falls back to `serIn`.
- R6: With `crcEn`=1, the first bit of time slot 0 in a frame with `fasFrame`=1 carries `crcBit`. This overrides R5.
- R7: With `autoEbit`=1, the first bit of time slot 0 in a frame with `fasFrame`=0 whose `frameIdx` is 13 or 15 carries the inverse of `eReq`. This overrides R5. In other frames `autoEbit` has no effect.
- R8: With `sigOnes`=1, every bit of time slot 16 is output as 1.
- R9: With `unframedOnes`=1, every output bit is 1, whatever the position or the other controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial transmit payload and overhead bit |
| tsIdx | input | 5 | Time slot of the current bit (0 to 31) |
| bitIdx | input | 3 | Bit within the slot, 0 = first transmitted bit (bit 1) |
| fasFrame | input | 1 | 1 when the current frame carries the alignment word |
| frameIdx | input | 4 | Frame number within the 16-frame multiframe |
| crcBit | input | 1 | Externally computed CRC bit for the current position |
| eReq | input | 1 | Receive-side request to report a CRC error |
| fasReg | input | 8 | Overhead byte for frames with the alignment word, bit 7 = first bit |
| nfasReg | input | 8 | Overhead byte for frames without the alignment word, bit 7 = first bit |
| passThru | input | 1 | Take time slot 0 overhead from `serIn` |
| intlSel | input | 1 | Take the first bit of time slot 0 from the registers |
| crcEn | input | 1 | Insert `crcBit` in the first bit of alignment frames |
| autoEbit | input | 1 | Generate E-bits from `eReq` |
| sigOnes | input | 1 | Force time slot 16 to all ones |
| unframedOnes | input | 1 | Force the whole output to ones |
| txData | output | 1 | Formatted serial output, one clock behind the inputs |

## Verification
A wrong source decision inside the block appears on `txData` one clock after the offending position, because only one register lies between the decode and the port. A misdecoded bit position shows up as a corrupted alignment word or a spare bit taken from the wrong register bit. A broken override priority shows up as a zero leaking through during unframed ones, or as time slot 16 data that is not forced high. The vector table sets a payload bit that opposes the expected overhead value at every overhead position, so any wrong source choice flips the sampled output.

// File: rtl/txoh_pkg.sv
package txoh_pkg;
  typedef enum logic [2:0] {
    SRC_SER,
    SRC_ONE,
    SRC_ZERO,
    SRC_REG,
    SRC_CRC,
    SRC_EBIT
  } srcSel_e;

  typedef struct packed {
    srcSel_e    src;
    logic       useNfas;
    logic [2:0] regBit;
  } txohStrobe_t;

  // bits 2..8 of time slot 0 in alignment frames, MSB = bit 2
  localparam logic [6:0] FAS_WORD = 7'b0011011;
endpackage

// File: rtl/txoh_ctrl.sv
module txoh_ctrl
  import txoh_pkg::*;
#(
  parameter int TS_W     = 5,
  parameter int BIT_W    = 3,
  parameter int FRM_W    = 4,
  parameter int SIG_TS   = 16,
  parameter int E_FRAME_A = 13,
  parameter int E_FRAME_B = 15
) (
  input  logic [TS_W-1:0]  tsIdx,
  input  logic [BIT_W-1:0] bitIdx,
  input  logic             fasFrame,
  input  logic [FRM_W-1:0] frameIdx,
  input  logic             passThru,
  input  logic             intlSel,
  input  logic             crcEn,
  input  logic             autoEbit,
  input  logic             sigOnes,
  input  logic             unframedOnes,
  output txohStrobe_t      strobe
);
  localparam logic [TS_W-1:0]  TS_SIG = TS_W'(SIG_TS);
  localparam logic [FRM_W-1:0] FR_EA  = FRM_W'(E_FRAME_A);
  localparam logic [FRM_W-1:0] FR_EB  = FRM_W'(E_FRAME_B);

  logic inTs0, siPos, eFrame;

  assign inTs0  = (tsIdx == '0);
  assign siPos  = inTs0 && (bitIdx == '0);
  assign eFrame = !fasFrame && ((frameIdx == FR_EA) || (frameIdx == FR_EB));

  always_comb begin
    strobe.src     = SRC_SER;
    strobe.useNfas = !fasFrame;
    strobe.regBit  = bitIdx;
    if (unframedOnes) begin
      strobe.src = SRC_ONE;
    end else if (sigOnes && tsIdx == TS_SIG) begin
      strobe.src = SRC_ONE;
    end else if (siPos) begin
      if (crcEn && fasFrame)           strobe.src = SRC_CRC;
      else if (autoEbit && eFrame)     strobe.src = SRC_EBIT;
      else if (intlSel && !passThru)   strobe.src = SRC_REG;
      else                             strobe.src = SRC_SER;
    end else if (inTs0 && !passThru) begin
      if (fasFrame)
        strobe.src = FAS_WORD[7 - 32'(bitIdx)] ? SRC_ONE : SRC_ZERO;
      else if (bitIdx == BIT_W'(1))
        strobe.src = SRC_ONE;
      else
        strobe.src = SRC_REG;
    end
  end

  // r9: unframed ones must always select a constant one
  always_comb begin
    if (unframedOnes) a_r9_unframed_src : assert (strobe.src == SRC_ONE);
  end
endmodule

// File: rtl/txoh_dpath.sv
module txoh_dpath
  import txoh_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  txohStrobe_t      strobe,
  input  logic             serIn,
  input  logic             crcBit,
  input  logic             eReq,
  input  logic [REG_W-1:0] fasReg,
  input  logic [REG_W-1:0] nfasReg,
  output logic             txData
);
  localparam int IDX_W = $clog2(REG_W);

  logic [REG_W-1:0] regSel;
  logic [IDX_W-1:0] regIdx;
  logic             nextBit;

  assign regSel = strobe.useNfas ? nfasReg : fasReg;
  assign regIdx = IDX_W'(REG_W - 1) - IDX_W'(strobe.regBit);

  always_comb begin
    unique case (strobe.src)
      SRC_ONE:  nextBit = 1'b1;
      SRC_ZERO: nextBit = 1'b0;
      SRC_REG:  nextBit = regSel[regIdx];
      SRC_CRC:  nextBit = crcBit;
      SRC_EBIT: nextBit = !eReq;
      default:  nextBit = serIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) txData <= 1'b1;
    else       txData <= nextBit;
  end

  // r1: the output leaves reset high
  a_r1_reset_high : assert property (@(posedge clk)
    $rose(rstN) |-> txData);
endmodule

// File: rtl/txoh_fmt.sv
module txoh_fmt
  import txoh_pkg::*;
#(
  parameter int TS_W  = 5,
  parameter int BIT_W = 3,
  parameter int FRM_W = 4,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic [TS_W-1:0]  tsIdx,
  input  logic [BIT_W-1:0] bitIdx,
  input  logic             fasFrame,
  input  logic [FRM_W-1:0] frameIdx,
  input  logic             crcBit,
  input  logic             eReq,
  input  logic [REG_W-1:0] fasReg,
  input  logic [REG_W-1:0] nfasReg,
  input  logic             passThru,
  input  logic             intlSel,
  input  logic             crcEn,
  input  logic             autoEbit,
  input  logic             sigOnes,
  input  logic             unframedOnes,
  output logic             txData
);
  txohStrobe_t strobe;

  txoh_ctrl #(.TS_W(TS_W), .BIT_W(BIT_W), .FRM_W(FRM_W)) u_ctrl (
    .tsIdx(tsIdx), .bitIdx(bitIdx), .fasFrame(fasFrame), .frameIdx(frameIdx),
    .passThru(passThru), .intlSel(intlSel), .crcEn(crcEn), .autoEbit(autoEbit),
    .sigOnes(sigOnes), .unframedOnes(unframedOnes), .strobe(strobe)
  );

  txoh_dpath #(.REG_W(REG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serIn(serIn), .crcBit(crcBit),
    .eReq(eReq), .fasReg(fasReg), .nfasReg(nfasReg), .txData(txData)
  );

  a_r9_unframed_ones : assert property (@(posedge clk) disable iff (!rstN)
    unframedOnes |=> txData);

  a_r8_sig_ones : assert property (@(posedge clk) disable iff (!rstN)
    (sigOnes && tsIdx == TS_W'(16)) |=> txData);

  a_r2_payload_latency : assert property (@(posedge clk) disable iff (!rstN)
    (!unframedOnes && tsIdx != '0 && tsIdx != TS_W'(16)) |=> (txData == $past(serIn)));

  a_r3_fas_bit2_zero : assert property (@(posedge clk) disable iff (!rstN)
    (!unframedOnes && !passThru && fasFrame && tsIdx == '0 && bitIdx == BIT_W'(1))
      |=> !txData);

  a_r4_nfas_bit2_one : assert property (@(posedge clk) disable iff (!rstN)
    (!unframedOnes && !passThru && !fasFrame && tsIdx == '0 && bitIdx == BIT_W'(1))
      |=> txData);
endmodule

// File: tb/test_txoh_fmt.sv
module test_txoh_fmt;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0, fasFrame = 1'b0, crcBit = 1'b0, eReq = 1'b0;
  logic [4:0] tsIdx = '0;
  logic [2:0] bitIdx = '0;
  logic [3:0] frameIdx = '0;
  logic [7:0] fasReg = 8'hC0;
  logic [7:0] nfasReg = 8'h69;
  logic passThru = 1'b0, intlSel = 1'b0, crcEn = 1'b0, autoEbit = 1'b0;
  logic sigOnes = 1'b0, unframedOnes = 1'b0;
  logic txData;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txoh_fmt i_txoh_fmt (
    .clk(clk), .rstN(rstN), .serIn(serIn), .tsIdx(tsIdx), .bitIdx(bitIdx),
    .fasFrame(fasFrame), .frameIdx(frameIdx), .crcBit(crcBit), .eReq(eReq),
    .fasReg(fasReg), .nfasReg(nfasReg), .passThru(passThru), .intlSel(intlSel),
    .crcEn(crcEn), .autoEbit(autoEbit), .sigOnes(sigOnes),
    .unframedOnes(unframedOnes), .txData(txData)
  );

  // fields: unfr sig pass intl crcEn autoE fasFr | frame[4] | ts[5] | bit[3] | ser crc eReq 0 exp
  localparam int NV = 20;
  localparam logic [23:0] VEC [NV] = '{
    24'b0000001_0000_00101_011_1_0_0_0_1, // R2 payload one
    24'b0000001_0000_00101_011_0_0_0_0_0, // R2 payload zero
    24'b0000001_0000_00000_001_1_0_0_0_0, // R3 bit2 of alignment word
    24'b0000001_0000_00000_011_0_0_0_0_1, // R3 bit4 of alignment word
    24'b0010001_0000_00000_011_0_0_0_0_0, // R3 pass-through
    24'b0000000_0001_00000_001_0_0_0_0_1, // R4 bit2 forced one
    24'b0000000_0001_00000_010_0_0_0_0_1, // R4 bit3 from nfasReg[5]
    24'b0000000_0001_00000_011_1_0_0_0_0, // R4 bit4 from nfasReg[4]
    24'b0000001_0000_00000_000_0_0_0_0_0, // R5 Si from serial
    24'b0001001_0000_00000_000_0_0_0_0_1, // R5 Si from fasReg[7]
    24'b0001000_0001_00000_000_1_0_0_0_0, // R5 Si from nfasReg[7]
    24'b0011001_0000_00000_000_0_0_0_0_0, // R5 invalid combination uses serial
    24'b0001101_0000_00000_000_1_0_0_0_0, // R6 crc bit inserted
    24'b0000010_1101_00000_000_1_0_1_0_0, // R7 frame 13 error reported
    24'b0000010_1111_00000_000_0_0_0_0_1, // R7 frame 15 no error
    24'b0000010_1011_00000_000_1_0_1_0_1, // R7 frame 11 unaffected
    24'b0100000_0000_10000_100_0_0_0_0_1, // R8 slot 16 forced
    24'b0100000_0000_10001_100_0_0_0_0_0, // R8 slot 17 untouched
    24'b1000001_0000_00000_001_0_0_0_0_1, // R9 over alignment word
    24'b1010000_0000_00101_000_0_0_0_0_1  // R9 over payload
  };

  task automatic apply(input logic [23:0] v);
    @(negedge clk);
    unframedOnes = v[23]; sigOnes = v[22]; passThru = v[21]; intlSel = v[20];
    crcEn = v[19]; autoEbit = v[18]; fasFrame = v[17]; frameIdx = v[16:13];
    tsIdx = v[12:8]; bitIdx = v[7:5]; serIn = v[4]; crcBit = v[3]; eReq = v[2];
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (txData !== exp) begin
      fails++;
      $display("FAIL %s: txData=%b expected=%b", req, txData, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    serIn = 1'b0; tsIdx = 5'd5;
    @(posedge clk);
    #1;
    check("R1", 1'b0); // first registered payload bit after release
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      case (i)
        0, 1:          check("R2", VEC[i][0]);
        2, 3, 4:       check("R3", VEC[i][0]);
        5, 6, 7:       check("R4", VEC[i][0]);
        8, 9, 10, 11:  check("R5", VEC[i][0]);
        12:            check("R6", VEC[i][0]);
        13, 14, 15:    check("R7", VEC[i][0]);
        16, 17:        check("R8", VEC[i][0]);
        default:       check("R9", VEC[i][0]);
      endcase
    end
    // R3 full alignment word sweep, payload opposing each bit
    for (int b = 1; b < 8; b++) begin
      logic e;
      e = 7'b0011011 >> (7 - b);
      apply({7'b0000001, 4'd0, 5'd0, 3'(b), ~e, 3'b000, e});
      check("R3", e);
    end
    // R4 spare bits 3..8 sweep against nfasReg
    for (int b = 2; b < 8; b++) begin
      logic e;
      e = nfasReg[7 - b];
      apply({7'b0000000, 4'd3, 5'd0, 3'(b), ~e, 3'b000, e});
      check("R4", e);
    end
    // R6 crc bit one, and crcEn ignored in non-alignment frame
    apply(24'b0000101_0000_00000_000_0_1_0_0_1);
    check("R6", 1'b1);
    apply(24'b0000100_0001_00000_000_0_1_0_0_0);
    check("R6", 1'b0);
    // R9 over signalling slot with everything enabled
    apply(24'b1111111_1101_10000_000_0_0_1_0_1);
    check("R9", 1'b1);
    // R1 reset reasserted mid-stream
    @(negedge clk);
    rstN = 1'b0; unframedOnes = 1'b0; sigOnes = 1'b0; tsIdx = 5'd7; serIn = 1'b0;
    @(posedge clk);
    #1;
    check("R1", 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: txData=%b expected=completion", txData);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule